// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable stand-in for a small serial EEPROM that stores 16-bit words. A host drives a select line, a serial clock and a serial data input, and reads one serial data output. The model runs on the chip's system clock and finds serial-clock rising edges by sampling. The storage is a register file inside the model, so the block can sit in a test chip or an emulation build wherever a real memory part would hang off a controller.

Each frame starts with a 1 bit, then a two-bit opcode, then an address field, then 16 data bits for the two write forms. A write-permit latch guards every instruction that changes the array. Reads return a single zero followed by the word, MSB first. After an instruction that changed the array, the next time select goes high the output shows a busy level and then a ready level. A parameter chooses a 6-bit or an 8-bit address field.

Top module: `eep_model`

## Requirements
- R1: After reset the output is 0, the write-permit latch is clear and every stored word reads 16'hFFFF.
- R2: While select is high and the model is waiting, a 0 sampled on a serial-clock rising edge is skipped; the frame begins at the first 1.
- R3: Opcode bits (first bit sent first): 10 reads, 01 writes one word, 11 erases one word. 00 is an extended form chosen by the two top address bits: 11 sets the write-permit latch, 00 clears it, 10 erases all words, 01 writes all words. The lower address bits of an extended form have no effect.
- R4: The address field is 6 bits when WIDE_ADDR is 0 and 8 bits when it is 1, sent MSB first. Addresses that differ only in bit 7 are distinct words in the 8-bit mode.
- R5: On a read, after the rising edge that takes the last address bit the output is 0. Each following rising edge presents the next stored bit, MSB first.
- R6: A one-word write stores the 16 bits that follow the address, MSB first. The write-all form stores its 16 bits in every word.
- R7: Erase sets the addressed word to 16'hFFFF. Erase-all sets every word to 16'hFFFF.
- R8: Write, write-all, erase and erase-all change nothing while the write-permit latch is clear.
- R9: Driving select low returns the model to waiting for a start bit. A frame cut short changes no stored word.
- R10: After an instruction that changed the array, the next rise of select makes the output 0 for BUSY_CYCLES system-clock cycles and then 1, until select falls. An instruction blocked by R8 produces no busy period.
- R11: Rising edges after the last read bit drive the output to 0. No further word is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Device select, active high |
| sck_i | input | 1 | Serial clock, sampled; rising edges shift bits |
| sdi_i | input | 1 | Serial data into the model |
| sdo_o | output | 1 | Serial data out: read bits, busy/ready level |

## Verification
The bench builds two copies side by side: one with WIDE_ADDR 0 and one with WIDE_ADDR 1, both with BUSY_CYCLES 5. The narrow copy covers the 6-bit frame length, the latch guard and the cut-short frame. The wide copy reaches addresses above 63 and shows that addresses differing only in the top bit stay apart. A short busy count lets the bench time both the last busy cycle and the first ready cycle exactly after every programming frame.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int WORD_W = 16;
    localparam int CNT_W  = 5;

    typedef enum logic [1:0] {
        OPC_EXT   = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_ERASE = 2'b11
    } opc_e;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_ERALL,
        CMD_WRALL,
        CMD_PERMIT,
        CMD_LOCK
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_HOLD,
        ST_STATUS
    } state_e;

    typedef struct packed {
        logic              one;
        logic              all;
        logic [WORD_W-1:0] data;
    } mem_req_t;

    function automatic cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] sub);
        cmd_e c;
        case (opc)
            OPC_READ:  c = CMD_READ;
            OPC_WRITE: c = CMD_WRITE;
            OPC_ERASE: c = CMD_ERASE;
            default: begin
                case (sub)
                    2'b11:   c = CMD_PERMIT;
                    2'b10:   c = CMD_ERALL;
                    2'b01:   c = CMD_WRALL;
                    default: c = CMD_LOCK;
                endcase
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/eep_pins.sv
module eep_pins (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    input  logic sck_i,
    output logic sck_rise,
    output logic sel_rise
);
    logic sck_q;
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            sck_q <= sck_i;
            sel_q <= sel_i;
        end
    end

    assign sck_rise = sck_i & ~sck_q & sel_i;
    assign sel_rise = sel_i & ~sel_q;

endmodule

// File: rtl/eep_array.sv
module eep_array
    import eep_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  mem_req_t          req,
    input  logic [AW-1:0]     wr_addr,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (req.all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= req.data;
        end else if (req.one) begin
            mem[wr_addr] <= req.data;
        end
    end

    assign rd_data = mem[rd_addr];

    a_r6_single_mode: assert property (@(posedge clk) disable iff (rst)
        !(req.one && req.all));

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int AW          = 6,
    parameter int BUSY_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              sdi_i,
    input  logic              sck_rise,
    input  logic              sel_rise,
    input  logic [WORD_W-1:0] rd_data,
    output mem_req_t          req,
    output logic [AW-1:0]     wr_addr,
    output logic [AW-1:0]     rd_addr,
    output logic              sdo_o
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(AW - 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] READ_END  = CNT_W'(WORD_W);

    state_e            state_q;
    logic [1:0]        opc_q;
    logic [AW-1:0]     addr_q;
    logic [WORD_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wel_q;
    logic              pend_q;
    logic [BW-1:0]     busy_q;
    logic              dout_q;

    logic [AW-1:0]     addr_next;
    logic [WORD_W-1:0] data_next;
    cmd_e              cmd_addr;
    cmd_e              cmd_data;
    logic              last_addr;
    logic              last_data;
    logic              pgm_fire;

    assign addr_next = {addr_q[AW-2:0], sdi_i};
    assign data_next = {data_q[WORD_W-2:0], sdi_i};
    assign cmd_addr  = decode_cmd(opc_q, addr_next[AW-1:AW-2]);
    assign cmd_data  = decode_cmd(opc_q, addr_q[AW-1:AW-2]);
    assign last_addr = (cnt_q == LAST_ADDR);
    assign last_data = (cnt_q == LAST_DATA);
    assign rd_addr   = addr_next;
    assign wr_addr   = (state_q == ST_DATA) ? addr_q : addr_next;

    always_comb begin
        req = '0;
        if (state_q == ST_ADDR && sck_rise && last_addr && wel_q) begin
            if (cmd_addr == CMD_ERASE) begin
                req.one  = 1'b1;
                req.data = '1;
            end else if (cmd_addr == CMD_ERALL) begin
                req.all  = 1'b1;
                req.data = '1;
            end
        end else if (state_q == ST_DATA && sck_rise && last_data && wel_q) begin
            if (cmd_data == CMD_WRITE) begin
                req.one  = 1'b1;
                req.data = data_next;
            end else if (cmd_data == CMD_WRALL) begin
                req.all  = 1'b1;
                req.data = data_next;
            end
        end
    end

    assign pgm_fire = req.one | req.all;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            opc_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            cnt_q   <= '0;
            wel_q   <= 1'b0;
            pend_q  <= 1'b0;
            busy_q  <= '0;
            dout_q  <= 1'b0;
        end else if (!sel_i) begin
            state_q <= ST_IDLE;
            dout_q  <= 1'b0;
        end else if (sel_rise) begin
            dout_q <= 1'b0;
            cnt_q  <= '0;
            if (pend_q) begin
                state_q <= ST_STATUS;
                busy_q  <= BW'(BUSY_CYCLES);
                pend_q  <= 1'b0;
            end else begin
                state_q <= ST_IDLE;
            end
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (sck_rise && sdi_i) begin
                        state_q <= ST_OPC;
                        cnt_q   <= '0;
                    end
                end
                ST_OPC: begin
                    if (sck_rise) begin
                        opc_q <= {opc_q[0], sdi_i};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(1)) begin
                            state_q <= ST_ADDR;
                            cnt_q   <= '0;
                        end
                    end
                end
                ST_ADDR: begin
                    if (sck_rise) begin
                        addr_q <= addr_next;
                        cnt_q  <= cnt_q + 1'b1;
                        if (last_addr) begin
                            cnt_q <= '0;
                            case (cmd_addr)
                                CMD_READ: begin
                                    data_q  <= rd_data;
                                    dout_q  <= 1'b0;
                                    state_q <= ST_READ;
                                end
                                CMD_WRITE, CMD_WRALL: state_q <= ST_DATA;
                                CMD_PERMIT: begin
                                    wel_q   <= 1'b1;
                                    state_q <= ST_HOLD;
                                end
                                CMD_LOCK: begin
                                    wel_q   <= 1'b0;
                                    state_q <= ST_HOLD;
                                end
                                default: begin
                                    if (pgm_fire) pend_q <= 1'b1;
                                    state_q <= ST_HOLD;
                                end
                            endcase
                        end
                    end
                end
                ST_DATA: begin
                    if (sck_rise) begin
                        data_q <= data_next;
                        cnt_q  <= cnt_q + 1'b1;
                        if (last_data) begin
                            if (pgm_fire) pend_q <= 1'b1;
                            state_q <= ST_HOLD;
                        end
                    end
                end
                ST_READ: begin
                    if (sck_rise) begin
                        if (cnt_q == READ_END) begin
                            dout_q  <= 1'b0;
                            state_q <= ST_HOLD;
                        end else begin
                            dout_q <= data_q[WORD_W-1];
                            data_q <= {data_q[WORD_W-2:0], 1'b0};
                            cnt_q  <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_STATUS: begin
                    if (busy_q != '0) busy_q <= busy_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign sdo_o = (state_q == ST_STATUS) ? (busy_q == '0) : dout_q;

    a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wel_q && !sdo_o));

    a_r2_skip_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && sck_rise && !sdi_i && !sel_rise) |=> (state_q == ST_IDLE));

    a_r5_dummy_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADDR && sck_rise && last_addr && cmd_addr == CMD_READ && !sel_rise)
        |=> (state_q == ST_READ && !sdo_o));

    a_r9_sel_low_idle: assert property (@(posedge clk) disable iff (rst)
        !sel_i |=> (state_q == ST_IDLE));

    a_r10_status_entry: assert property (@(posedge clk) disable iff (rst)
        (sel_i && sel_rise && pend_q) |=> (state_q == ST_STATUS && !sdo_o));

    a_r11_read_tail: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READ && sck_rise && cnt_q == READ_END && !sel_rise)
        |=> (state_q == ST_HOLD && !sdo_o));

endmodule

// File: rtl/eep_model.sv
module eep_model
    import eep_pkg::*;
#(
    parameter bit WIDE_ADDR   = 1'b0,
    parameter int BUSY_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sdo_o
);
    localparam int AW = WIDE_ADDR ? 8 : 6;

    logic              sck_rise;
    logic              sel_rise;
    mem_req_t          req;
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] rd_data;

    eep_pins u_pins (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (sel_i),
        .sck_i    (sck_i),
        .sck_rise (sck_rise),
        .sel_rise (sel_rise)
    );

    eep_ctrl #(
        .AW          (AW),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (sel_i),
        .sdi_i    (sdi_i),
        .sck_rise (sck_rise),
        .sel_rise (sel_rise),
        .rd_data  (rd_data),
        .req      (req),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .sdo_o    (sdo_o)
    );

    eep_array #(
        .AW (AW)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/test_eep_model.sv
`timescale 1ns/1ps
module test_eep_model;

    localparam int BUSY = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = 2'b00;
    logic [1:0] sck = 2'b00;
    logic [1:0] sdi = 2'b00;
    logic       dout_n;
    logic       dout_w;

    always #2.5 clk = ~clk;

    eep_model #(.WIDE_ADDR(1'b0), .BUSY_CYCLES(BUSY)) i_eep_model (
        .clk(clk), .rst(rst), .sel_i(sel[0]), .sck_i(sck[0]), .sdi_i(sdi[0]), .sdo_o(dout_n));

    eep_model #(.WIDE_ADDR(1'b1), .BUSY_CYCLES(BUSY)) i_eep_model_wide (
        .clk(clk), .rst(rst), .sel_i(sel[1]), .sck_i(sck[1]), .sdi_i(sdi[1]), .sdo_o(dout_w));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [15:0] ref_n [64];
    logic [15:0] ref_w [256];
    bit          wel_ref [2];

    typedef struct {
        string       tag;
        logic [15:0] val;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] act_q[$];

    function automatic logic get_dout(input int w);
        return (w == 1) ? dout_w : dout_n;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares each read word against the scoreboard entry
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() > 0 && exp_q.size() > 0) begin
                exp_t        e;
                logic [15:0] a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                check(e.tag, a, e.val);
            end
        end
    end

    task automatic bit_t(input int w, input logic b, output logic o);
        @(negedge clk);
        sdi[w] = b;
        sck[w] = 1'b0;
        repeat (2) @(negedge clk);
        sck[w] = 1'b1;
        repeat (3) @(negedge clk);
        o = get_dout(w);
    endtask

    task automatic sel_on(input int w);
        @(negedge clk);
        sck[w] = 1'b0;
        sel[w] = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic sel_off(input int w);
        @(negedge clk);
        sck[w] = 1'b0;
        sel[w] = 1'b0;
        sdi[w] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_hdr(input int w, input int lead, input logic [1:0] opc,
                            input logic [7:0] addr, output logic o);
        int aw;
        aw = (w == 1) ? 8 : 6;
        for (int i = 0; i < lead; i++) bit_t(w, 1'b0, o);
        bit_t(w, 1'b1, o);
        bit_t(w, opc[1], o);
        bit_t(w, opc[0], o);
        for (int i = aw - 1; i >= 0; i--) bit_t(w, addr[i], o);
    endtask

    task automatic ref_set(input int w, input logic [7:0] a, input logic [15:0] d);
        if (w == 1) ref_w[a] = d;
        else        ref_n[a[5:0]] = d;
    endtask

    task automatic ref_all(input int w, input logic [15:0] d);
        if (w == 1) for (int i = 0; i < 256; i++) ref_w[i] = d;
        else        for (int i = 0; i < 64; i++)  ref_n[i] = d;
    endtask

    // R10: busy for BUSY cycles after select rises, then ready
    task automatic chk_status(input int w, input bit executed);
        @(negedge clk);
        sck[w] = 1'b0;
        sel[w] = 1'b1;
        for (int k = 1; k <= BUSY + 1; k++) begin
            @(negedge clk);
            if (k == 1)        check("R10 first busy", {15'd0, get_dout(w)}, 16'd0);
            if (k == BUSY)     check("R10 last busy", {15'd0, get_dout(w)}, 16'd0);
            if (k == BUSY + 1) check("R10 ready", {15'd0, get_dout(w)}, {15'd0, executed});
        end
        sel_off(w);
    endtask

    task automatic do_read(input int w, input int lead, input logic [7:0] addr, input string tag);
        logic        o;
        logic [15:0] v;
        exp_t        e;
        sel_on(w);
        send_hdr(w, lead, 2'b10, addr, o);
        check({tag, " R5 dummy zero"}, {15'd0, o}, 16'd0);
        e.tag = tag;
        e.val = (w == 1) ? ref_w[addr] : ref_n[addr[5:0]];
        exp_q.push_back(e);
        v = '0;
        for (int i = 0; i < 16; i++) begin
            bit_t(w, 1'b0, o);
            v = {v[14:0], o};
        end
        act_q.push_back(v);
        bit_t(w, 1'b0, o);
        check("R11 tail zero", {15'd0, o}, 16'd0);
        sel_off(w);
    endtask

    task automatic do_write(input int w, input logic [7:0] addr, input logic [15:0] d);
        logic o;
        sel_on(w);
        send_hdr(w, 0, 2'b01, addr, o);
        for (int i = 15; i >= 0; i--) bit_t(w, d[i], o);
        sel_off(w);
        if (wel_ref[w]) ref_set(w, addr, d);
        chk_status(w, wel_ref[w]);
    endtask

    task automatic do_erase(input int w, input logic [7:0] addr);
        logic o;
        sel_on(w);
        send_hdr(w, 0, 2'b11, addr, o);
        sel_off(w);
        if (wel_ref[w]) ref_set(w, addr, 16'hFFFF);
        chk_status(w, wel_ref[w]);
    endtask

    // extended forms: sub-op in the top two address bits, junk below (R3)
    task automatic do_ext(input int w, input logic [1:0] sub, input logic [15:0] d);
        logic       o;
        logic [7:0] a;
        a = (w == 1) ? {sub, 6'b101101} : {2'b00, sub, 4'b1011};
        sel_on(w);
        send_hdr(w, 0, 2'b00, a, o);
        if (sub == 2'b01) for (int i = 15; i >= 0; i--) bit_t(w, d[i], o);
        sel_off(w);
        case (sub)
            2'b11: wel_ref[w] = 1'b1;
            2'b00: wel_ref[w] = 1'b0;
            2'b10: begin
                if (wel_ref[w]) ref_all(w, 16'hFFFF);
                chk_status(w, wel_ref[w]);
            end
            default: begin
                if (wel_ref[w]) ref_all(w, d);
                chk_status(w, wel_ref[w]);
            end
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic o;
        ref_all(0, 16'hFFFF);
        ref_all(1, 16'hFFFF);
        wel_ref[0] = 1'b0;
        wel_ref[1] = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        check("R1 reset dout narrow", {15'd0, dout_n}, 16'd0);
        check("R1 reset dout wide", {15'd0, dout_w}, 16'd0);
        do_read(0, 0, 8'd5, "R1 erased after reset");

        // R8: latch clear after reset, write blocked
        do_write(0, 8'd5, 16'hA5C3);
        do_read(0, 0, 8'd5, "R8 blocked write");

        // R3 permit with junk low bits, R6 writes
        do_ext(0, 2'b11, 16'h0);
        do_write(0, 8'd5, 16'hA5C3);
        do_write(0, 8'd63, 16'h1234);
        do_read(0, 0, 8'd5, "R6 write narrow");
        do_read(0, 2, 8'd63, "R2 leading zeros");

        // R7 single erase
        do_erase(0, 8'd5);
        do_read(0, 0, 8'd5, "R7 erase word");
        do_read(0, 0, 8'd63, "R7 neighbour kept");

        // R9: cut-short write changes nothing, no busy afterwards
        sel_on(0);
        send_hdr(0, 0, 2'b01, 8'd63, o);
        for (int i = 0; i < 8; i++) bit_t(0, 1'b0, o);
        sel_off(0);
        do_read(0, 0, 8'd63, "R9 aborted write");

        // R8: lock again, erase blocked
        do_ext(0, 2'b00, 16'h0);
        do_erase(0, 8'd63);
        do_read(0, 0, 8'd63, "R8 blocked erase");

        // wide array: R4 distinct top-bit addresses
        do_ext(1, 2'b11, 16'h0);
        do_write(1, 8'd200, 16'hBEEF);
        do_write(1, 8'h3F, 16'h0F0F);
        do_read(1, 0, 8'd200, "R4 wide addr 200");
        do_read(1, 0, 8'h3F, "R4 wide addr 3F");
        do_read(1, 0, 8'hBF, "R4 wide addr BF untouched");

        // R6 write-all, R7 erase-all
        do_ext(1, 2'b01, 16'h5A5A);
        do_read(1, 0, 8'd17, "R6 write-all 17");
        do_read(1, 0, 8'd255, "R6 write-all 255");
        do_ext(1, 2'b10, 16'h0);
        do_read(1, 0, 8'd3, "R7 erase-all");

        // R8 wide: lock then write blocked
        do_ext(1, 2'b00, 16'h0);
        do_write(1, 8'd9, 16'h1111);
        do_read(1, 0, 8'd9, "R8 wide blocked");

        repeat (10) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule